// File: doc/BRIEF.md
# Shifted-Operand Test Flag Unit

This execute-stage unit performs a logical test. It takes two register operands and moves the second one by a selectable shift kind and amount. It then ANDs the shifted value with the first operand and records the outcome in a four-bit condition flag set (N, Z, C, V). The AND value itself goes nowhere: the only lasting effect is the flag update. A width select picks either the full 64-bit datapath or a 32-bit view that uses only the low halves of the operands.

An operation is presented for one cycle with `op_valid` high, and one can be presented every cycle. The flags change on the next rising clock edge. The latency is the same whatever the operand data or the current flags are. In 32-bit mode, a shift amount of 32 or more is a reserved encoding. Such an operation leaves the flags untouched and is reported on `illegal` instead.

A small state register records what the last cycle did:
- `ST_IDLE`: no operation was offered.
- `ST_UPDATE`: the flags were rewritten.
- `ST_REJECT`: a reserved encoding was refused.

Every state moves to `ST_UPDATE` on a legal valid operation, to `ST_REJECT` on a reserved one, and to `ST_IDLE` when `op_valid` is low. `illegal` is high exactly while the state is `ST_REJECT`.

Top module: `tstflag_unit`

## Requirements
- R1: `shift_kind` selects how `opb` is moved before the AND: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R2: After an accepted operation, `flag_n` equals the most significant bit of the AND result at the selected width (bit 63 when `wide`=1, bit 31 when `wide`=0).
- R3: After an accepted operation, `flag_z` is 1 exactly when the AND result at the selected width is all zeros.
- R4: `flag_c` and `flag_v` are 0 after every accepted operation.
- R5: With `wide`=0, the upper 32 bits of both operands are ignored. Arithmetic right fills with bit 31, and rotate wraps within 32 bits.
- R6: With `wide`=1, every amount from 0 to 63 is legal and is applied across all 64 bits.
- R7: With `wide`=0 and bit 5 of `shift_amt` set, `illegal` is 1 in the cycle after the request and the flags keep their previous values.
- R8: Flags change exactly one clock edge after `op_valid` is high. While `op_valid` is low they hold, and `illegal` is 0 in the following cycle.
- R9: Reset (`rst_n` low) clears all four flags and `illegal`.
- R10: A left shift by 0 passes `opb` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered this cycle |
| wide | input | 1 | 1 selects 64-bit, 0 selects 32-bit |
| shift_kind | input | 2 | Shift kind for the second operand |
| shift_amt | input | 6 | Shift amount |
| opa | input | 64 | First operand |
| opb | input | 64 | Operand that is shifted |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| illegal | output | 1 | Last operation used a reserved amount |

## Verification
If the state register holds a wrong value, the fault shows at the ports one cycle after the request. Either `illegal` rises on a legal operation, or a refused operation still rewrites N and Z. A wrong shift lane or width select shows up as an N or Z value that differs from the hand-computed result on the same edge. The vectors are chosen so that a confused shift kind or width flips Z or N. A flag register that fails to hold shows up after several idle cycles, as a changed flag with `op_valid` low.

// File: rtl/tstflag_pkg.sv
package tstflag_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_UPDATE = 2'b01,
        ST_REJECT = 2'b10
    } unit_state_e;

endpackage

// File: rtl/tstflag_shifter.sv
module tstflag_shifter
    import tstflag_pkg::*;
#(
    parameter int W = 64,
    localparam int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [2*W-1:0]       doubled;
    logic signed [W-1:0]  sdin;

    always_comb begin
        doubled = {din, din} >> amt;
        sdin    = din;
        unique case (shift_kind_e'(kind))
            SK_LSL:  dout = din << amt;
            SK_LSR:  dout = din >> amt;
            SK_ASR:  dout = sdin >>> amt;
            SK_ROR:  dout = doubled[W-1:0];
            default: dout = din;
        endcase
    end

endmodule

// File: rtl/tstflag_flaggen.sv
module tstflag_flaggen #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_shifted,
    output logic         neg,
    output logic         zero
);

    logic [W-1:0] masked;

    always_comb begin
        masked = a & b_shifted;
        neg    = masked[W-1];
        zero   = ~|masked;
    end

endmodule

// File: rtl/tstflag_unit.sv
module tstflag_unit
    import tstflag_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              wide,
    input  logic [1:0]        shift_kind,
    input  logic [AMT_W-1:0]  shift_amt,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              illegal
);

    localparam int LANES = 2;

    logic [LANES-1:0] lane_n;
    logic [LANES-1:0] lane_z;

    // lane 0 is the full width, lane 1 the half width view
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW  = DATA_W >> g;
        localparam int LAW = $clog2(LW);
        logic [LW-1:0] shifted;

        tstflag_shifter #(.W(LW)) u_shift (
            .din   (opb[LW-1:0]),
            .kind  (shift_kind),
            .amt   (shift_amt[LAW-1:0]),
            .dout  (shifted)
        );

        tstflag_flaggen #(.W(LW)) u_flags (
            .a         (opa[LW-1:0]),
            .b_shifted (shifted),
            .neg       (lane_n[g]),
            .zero      (lane_z[g])
        );
    end

    logic        reserved_amt;
    logic        sel_n;
    logic        sel_z;
    unit_state_e st_q;
    unit_state_e st_d;
    logic [3:0]  nzcv_q;

    always_comb begin
        reserved_amt = !wide && (shift_amt >= AMT_W'(HALF_W));
        sel_n        = wide ? lane_n[0] : lane_n[1];
        sel_z        = wide ? lane_z[0] : lane_z[1];
        if (!op_valid)
            st_d = ST_IDLE;
        else if (reserved_amt)
            st_d = ST_REJECT;
        else
            st_d = ST_UPDATE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            nzcv_q <= 4'b0000;
        else if (st_d == ST_UPDATE)
            nzcv_q <= {sel_n, sel_z, 1'b0, 1'b0};
    end

    always_comb begin
        flag_n = nzcv_q[3];
        flag_z = nzcv_q[2];
        flag_c = nzcv_q[1];
        flag_v = nzcv_q[0];
        unique case (st_q)
            ST_IDLE:   illegal = 1'b0;
            ST_UPDATE: illegal = 1'b0;
            ST_REJECT: illegal = 1'b1;
            default:   illegal = 1'b0;
        endcase
    end

endmodule

// File: rtl/tstflag_unit_chk.sv
module tstflag_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic        wide,
    input logic [1:0]  shift_kind,
    input logic [5:0]  shift_amt,
    input logic [63:0] opa,
    input logic [63:0] opb,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_c,
    input logic        flag_v,
    input logic        illegal
);

    a_r7_reserved_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wide && shift_amt[5])
            |=> (illegal && $stable({flag_n, flag_z, flag_c, flag_v})));

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable({flag_n, flag_z, flag_c, flag_v}) && !illegal));

    a_r4_cv_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_c && !flag_v));

    a_r3_zero_not_neg: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n);

    a_r2_neg_needs_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && wide && !opa[63]) |=> !flag_n);

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || (!flag_n && !flag_z && !illegal)));

endmodule

bind tstflag_unit tstflag_unit_chk u_chk (.*);

// File: tb/tstflag_unit_bench.sv
`timescale 1ns/1ps
module tstflag_unit_bench;

    typedef struct packed {
        logic        wide;
        logic [1:0]  kind;
        logic [5:0]  amt;
        logic [63:0] a;
        logic [63:0] b;
        logic        en;
        logic        ez;
        logic        eill;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        // R10 R2: LSL 0 passes opb through, N from bit 63
        '{1'b1, 2'd0, 6'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0},
        // R6 R1: LSL 63
        '{1'b1, 2'd0, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b1, 1'b0, 1'b0},
        // R1: LSR 63
        '{1'b1, 2'd1, 6'd63, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0},
        // R1: ASR 8 sign fill reaches bit 56
        '{1'b1, 2'd2, 6'd8,  64'h0100_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0},
        // R1: ROR 4 wraps bit 0 to bit 60
        '{1'b1, 2'd3, 6'd4,  64'h1000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b0},
        // R3: disjoint bits give zero
        '{1'b1, 2'd0, 6'd1,  64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b0, 1'b1, 1'b0},
        // R5: upper halves ignored in 32-bit mode
        '{1'b0, 2'd0, 6'd0,  64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, 1'b0},
        // R5: ASR 31 fills from bit 31
        '{1'b0, 2'd2, 6'd31, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b1, 1'b0, 1'b0},
        // R5: ROR 1 wraps into bit 31
        '{1'b0, 2'd3, 6'd1,  64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 1'b1, 1'b0, 1'b0},
        // R7: amount 32 in 32-bit mode, flags kept from previous vector
        '{1'b0, 2'd0, 6'd32, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1, 1'b0, 1'b1},
        // R6: amount 32 legal in 64-bit mode
        '{1'b1, 2'd0, 6'd32, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        wide = 1'b1;
    logic [1:0]  shift_kind = 2'd0;
    logic [5:0]  shift_amt = 6'd0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        flag_n, flag_z, flag_c, flag_v, illegal;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tstflag_unit u_tstflag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .wide(wide),
        .shift_kind(shift_kind), .shift_amt(shift_amt), .opa(opa), .opb(opb),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {n,z,c,v,ill} actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {flag_n, flag_z, flag_c, flag_v, illegal};
    endfunction

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset state", outs(), 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 after release", outs(), 5'b00000);

        for (int i = 0; i < NV; i++) begin
            op_valid   = 1'b1;
            wide       = VEC[i].wide;
            shift_kind = VEC[i].kind;
            shift_amt  = VEC[i].amt;
            opa        = VEC[i].a;
            opb        = VEC[i].b;
            @(negedge clk);
            chk($sformatf("R1 R2 R3 R4 vector %0d", i), outs(),
                {VEC[i].en, VEC[i].ez, 2'b00, VEC[i].eill});
        end

        // R8: idle cycles hold flags, illegal drops
        op_valid = 1'b0;
        opa = '1; opb = '1;
        @(negedge clk);
        chk("R8 idle one", outs(), 5'b00000);
        repeat (3) @(negedge clk);
        chk("R8 idle hold", outs(), 5'b00000);

        // R8: single valid updates on next edge
        op_valid = 1'b1; wide = 1'b1; shift_kind = 2'd0; shift_amt = 6'd0;
        opa = 64'h8000_0000_0000_0000; opb = 64'h8000_0000_0000_0000;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R8 one edge update", outs(), 5'b10000);

        // R7: reserved amount keeps N=1 and raises illegal for one cycle
        op_valid = 1'b1; wide = 1'b0; shift_amt = 6'd63; opa = '0; opb = '0;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7 reserved 63", outs(), 5'b10001);
        @(negedge clk);
        chk("R7 illegal clears", outs(), 5'b10000);

        // R5: 32-bit LSR zero result ignores upper bits
        op_valid = 1'b1; wide = 1'b0; shift_kind = 2'd1; shift_amt = 6'd4;
        opa = 64'hFFFF_FFFF_0000_0000; opb = 64'hFFFF_FFFF_0000_0010;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R5 narrow LSR", outs(), 5'b01000);

        // R9: reset mid-run clears flags
        op_valid = 1'b1; wide = 1'b1; shift_kind = 2'd0; shift_amt = 6'd0;
        opa = 64'h8000_0000_0000_0000; opb = 64'h8000_0000_0000_0000;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9 pre-reset", outs(), 5'b10000);
        rst_n = 1'b0;
        #1;
        chk("R9 async clear", outs(), 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule